// File: doc/BRIEF.md
# Multi-Mode Bit-Serial Slip Buffer

This block sits between a system-side writer and a line-side reader of a bit-serial transmit stream carrying 256-bit frames. Both sides are presented as per-cycle strobes (`wr_en`, `rd_en`) on one clock; any synchronisation of the two rates is done outside. Each stored bit carries a frame-start marker, so the line side sees frame alignment together with the data.

A two-bit mode input selects the buffering policy. Two-frame mode holds up to two frames. It starts one frame deep, and on overflow or underflow it drops or repeats exactly one whole frame, which is a controlled slip. Elastic mode limits the depth to 64 bits and starts half full for low delay. On full or empty it re-centres to half depth, which is an uncontrolled slip. Short mode starts like elastic mode. Its first full or empty event is an uncontrolled slip that permanently moves it into two-frame behaviour. Bypass mode forwards the written bit to the output whenever the reader strobes.

Slip events produce one-cycle pulses and sticky flags that a clear pulse resets. A reset or a change of the mode input re-centres the read pointer at the initial delay of the selected mode.

Top module: `sb_slip_buffer`

## Requirements
- R1: Synchronous reset (`rst_n` low) or a change of `mode` sets `fill` to the mode's start delay: 256 for two-frame (`mode`=0), 32 for elastic (1) and short (2), 0 for bypass (3). It also clears `fell_back`. Strobes in that cycle are ignored. Reset also clears both sticky flags.
- R2: In the buffering modes, bits and frame markers come out on `rd_bit`/`rd_fs` in write order, registered one cycle after the `rd_en` cycle.
- R3: Without a slip, a write alone adds 1 to `fill`, a read alone subtracts 1, and both together or neither leave it unchanged. `fill` never exceeds 512.
- R4: In elastic mode, a write without a read at `fill`=64 raises `uslip_pulse` and sets `fill` to 32. The next 32 reads return the last 32 bits written.
- R5: In elastic mode, a read without a write at `fill`=0 raises `uslip_pulse` and sets `fill` to 32.
- R6: In two-frame mode, a write without a read at `fill`=512 raises `cslip_pulse` and sets `fill` to 257. Reading then continues exactly one frame later, so the frame markers stay 256 bits apart.
- R7: In two-frame mode, a read without a write at `fill`=0 raises `cslip_pulse`, sets `fill` to 255 and returns the bit stored one frame earlier.
- R8: Short mode applies the elastic limits until its first full or empty event. That event raises `uslip_pulse`, sets `fell_back`, and sets `fill` to 256. From then on the two-frame rules of R6 and R7 apply.
- R9: In bypass mode, `rd_bit`/`rd_fs` take `wr_bit`/`wr_fs` one cycle after an `rd_en` cycle and hold otherwise. `fill` stays 0 and no slip is reported.
- R10: A slip pulse sets its own sticky flag in the same cycle. `slip_clr` clears both flags, and a new slip wins over a clear.
- R11: Slip pulses last one cycle and are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 two-frame, 1 elastic, 2 short, 3 bypass |
| wr_en | input | 1 | Write strobe from system side |
| wr_bit | input | 1 | Write data bit |
| wr_fs | input | 1 | Frame-start marker of the written bit |
| rd_en | input | 1 | Read strobe from line side |
| slip_clr | input | 1 | Clears both sticky slip flags |
| rd_bit | output | 1 | Read data bit |
| rd_fs | output | 1 | Frame-start marker of the read bit |
| fill | output | 10 | Current fill level in bits |
| fell_back | output | 1 | Short mode has switched to two-frame rules |
| cslip_pulse | output | 1 | Controlled (whole-frame) slip this cycle |
| uslip_pulse | output | 1 | Uncontrolled slip this cycle |
| cslip_flag | output | 1 | Sticky controlled-slip flag |
| uslip_flag | output | 1 | Sticky uncontrolled-slip flag |

## Verification
On every cycle the assertions check several invariants: the fill bound, the elastic depth limit, bypass staying empty and quiet, mutually exclusive pulses, sticky flags following their pulses, the one-way fall-back latch, and controlled slips occurring only under two-frame rules. Only the bench scenarios can show the data-side facts. These are which bits come back after a frame drop, a frame repeat or an elastic re-centre, whether frame markers keep their 256-bit spacing, and the exact fill values after each slip and re-centre.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        SB_TWO_FRAME = 2'd0,
        SB_ELASTIC   = 2'd1,
        SB_SHORT     = 2'd2,
        SB_BYPASS    = 2'd3
    } sb_mode_e;
endpackage

// File: rtl/sb_bit_store.sv
module sb_bit_store #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [1:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [1:0]    rdata
);
    // each entry holds {frame marker, data bit}
    logic [1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl
    import sb_pkg::*;
#(
    parameter int FRAME_BITS   = 256,
    parameter int ELASTIC_BITS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  sb_mode_e                     mode,
    input  logic                         wr_en,
    input  logic                         wr_bit,
    input  logic                         wr_fs,
    input  logic                         rd_en,
    input  logic [1:0]                   rdata,
    output logic                         we,
    output logic [$clog2(2*FRAME_BITS)-1:0] waddr,
    output logic [$clog2(2*FRAME_BITS)-1:0] raddr,
    output logic                         rd_bit,
    output logic                         rd_fs,
    output logic [$clog2(2*FRAME_BITS):0] fill,
    output logic                         fell_back,
    output sb_mode_e                     cur_mode,
    output logic                         ev_cslip,
    output logic                         ev_uslip
);
    localparam int DEPTH = 2 * FRAME_BITS;
    localparam int AW    = $clog2(DEPTH);
    localparam int FW    = AW + 1;
    localparam int HALF  = ELASTIC_BITS / 2;

    localparam logic [AW-1:0] PTR_FRAME = AW'(FRAME_BITS);
    localparam logic [AW-1:0] PTR_HALF  = AW'(HALF);
    localparam logic [AW-1:0] PTR_ONE   = AW'(1);
    localparam logic [FW-1:0] FILL_FULL = FW'(DEPTH);
    localparam logic [FW-1:0] FILL_ELAS = FW'(ELASTIC_BITS);
    localparam logic [FW-1:0] FILL_FRM  = FW'(FRAME_BITS);
    localparam logic [FW-1:0] FILL_HALF = FW'(HALF);
    localparam logic [FW-1:0] FILL_ONE  = FW'(1);

    typedef struct packed {
        sb_mode_e      mode;
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [FW-1:0] fill;
        logic          fallen;
        logic          out_bit;
        logic          out_fs;
    } ctrl_t;

    ctrl_t q, d;

    logic          elastic_like;
    logic [FW-1:0] depth_lim;
    logic [FW-1:0] init_v;
    logic          over;
    logic          under;
    logic [AW-1:0] wr_next;

    function automatic logic [FW-1:0] start_fill(sb_mode_e m);
        case (m)
            SB_TWO_FRAME: return FILL_FRM;
            SB_BYPASS:    return '0;
            default:      return FILL_HALF;
        endcase
    endfunction

    always_comb begin
        d        = q;
        ev_cslip = 1'b0;
        ev_uslip = 1'b0;
        we       = 1'b0;
        waddr    = q.wr_ptr;
        raddr    = q.rd_ptr;
        init_v   = start_fill(mode);

        elastic_like = (q.mode == SB_ELASTIC) || (q.mode == SB_SHORT && !q.fallen);
        depth_lim    = elastic_like ? FILL_ELAS : FILL_FULL;
        over         = wr_en && !rd_en && (q.fill == depth_lim);
        under        = rd_en && !wr_en && (q.fill == '0);
        wr_next      = q.wr_ptr + (wr_en ? PTR_ONE : '0);

        if (!rst_n) begin
            d.mode    = mode;
            d.wr_ptr  = '0;
            d.rd_ptr  = '0 - init_v[AW-1:0];
            d.fill    = init_v;
            d.fallen  = 1'b0;
            d.out_bit = 1'b0;
            d.out_fs  = 1'b0;
        end else if (mode != q.mode) begin
            // re-centre for the newly selected mode; strobes ignored
            d.mode   = mode;
            d.rd_ptr = q.wr_ptr - init_v[AW-1:0];
            d.fill   = init_v;
            d.fallen = 1'b0;
        end else if (q.mode == SB_BYPASS) begin
            d.fill = '0;
            if (rd_en) begin
                d.out_bit = wr_bit;
                d.out_fs  = wr_fs;
            end
        end else begin
            we       = wr_en;
            d.wr_ptr = wr_next;
            if (rd_en) begin
                if (under && !elastic_like) begin
                    raddr = q.rd_ptr - PTR_FRAME;
                end
                d.out_fs  = rdata[1];
                d.out_bit = rdata[0];
            end
            d.rd_ptr = q.rd_ptr + (rd_en ? PTR_ONE : '0);
            d.fill   = q.fill + (wr_en ? FILL_ONE : '0) - (rd_en ? FILL_ONE : '0);
            if (over || under) begin
                if (elastic_like) begin
                    ev_uslip = 1'b1;
                    if (q.mode == SB_SHORT) begin
                        d.fallen = 1'b1;
                        d.rd_ptr = wr_next - PTR_FRAME;
                        d.fill   = FILL_FRM;
                    end else begin
                        d.rd_ptr = wr_next - PTR_HALF;
                        d.fill   = FILL_HALF;
                    end
                end else begin
                    ev_cslip = 1'b1;
                    if (over) begin
                        d.rd_ptr = q.rd_ptr + PTR_FRAME;
                        d.fill   = FILL_FRM + FILL_ONE;
                    end else begin
                        d.rd_ptr = q.rd_ptr - PTR_FRAME + PTR_ONE;
                        d.fill   = FILL_FRM - FILL_ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign rd_bit    = q.out_bit;
    assign rd_fs     = q.out_fs;
    assign fill      = q.fill;
    assign fell_back = q.fallen;
    assign cur_mode  = q.mode;
endmodule

// File: rtl/sb_slip_flags.sv
module sb_slip_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ev_cslip,
    input  logic ev_uslip,
    output logic cslip_pulse,
    output logic uslip_pulse,
    output logic cslip_flag,
    output logic uslip_flag
);
    typedef struct packed {
        logic cp;
        logic up;
        logic cs;
        logic us;
    } flags_t;

    flags_t q, d;

    always_comb begin
        d = q;
        if (!rst_n) begin
            d = '0;
        end else begin
            d.cp = ev_cslip;
            d.up = ev_uslip;
            d.cs = (q.cs && !clr) || ev_cslip;
            d.us = (q.us && !clr) || ev_uslip;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign cslip_pulse = q.cp;
    assign uslip_pulse = q.up;
    assign cslip_flag  = q.cs;
    assign uslip_flag  = q.us;
endmodule

// File: rtl/sb_slip_buffer.sv
module sb_slip_buffer
    import sb_pkg::*;
#(
    parameter int FRAME_BITS   = 256,
    parameter int ELASTIC_BITS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode,
    input  logic                          wr_en,
    input  logic                          wr_bit,
    input  logic                          wr_fs,
    input  logic                          rd_en,
    input  logic                          slip_clr,
    output logic                          rd_bit,
    output logic                          rd_fs,
    output logic [$clog2(2*FRAME_BITS):0] fill,
    output logic                          fell_back,
    output logic                          cslip_pulse,
    output logic                          uslip_pulse,
    output logic                          cslip_flag,
    output logic                          uslip_flag
);
    localparam int DEPTH = 2 * FRAME_BITS;
    localparam int AW    = $clog2(DEPTH);

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [1:0]    rdata;
    logic          ev_cslip;
    logic          ev_uslip;
    sb_mode_e      cur_mode;

    sb_bit_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata ({wr_fs, wr_bit}),
        .raddr (raddr),
        .rdata (rdata)
    );

    sb_ptr_ctrl #(.FRAME_BITS(FRAME_BITS), .ELASTIC_BITS(ELASTIC_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (sb_mode_e'(mode)),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .wr_fs     (wr_fs),
        .rd_en     (rd_en),
        .rdata     (rdata),
        .we        (we),
        .waddr     (waddr),
        .raddr     (raddr),
        .rd_bit    (rd_bit),
        .rd_fs     (rd_fs),
        .fill      (fill),
        .fell_back (fell_back),
        .cur_mode  (cur_mode),
        .ev_cslip  (ev_cslip),
        .ev_uslip  (ev_uslip)
    );

    sb_slip_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (slip_clr),
        .ev_cslip    (ev_cslip),
        .ev_uslip    (ev_uslip),
        .cslip_pulse (cslip_pulse),
        .uslip_pulse (uslip_pulse),
        .cslip_flag  (cslip_flag),
        .uslip_flag  (uslip_flag)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
#(
    parameter int FRAME_BITS   = 256,
    parameter int ELASTIC_BITS = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [1:0]                    mode,
    input sb_mode_e                      cur_mode,
    input logic [$clog2(2*FRAME_BITS):0] fill,
    input logic                          fell_back,
    input logic                          cslip_pulse,
    input logic                          uslip_pulse,
    input logic                          cslip_flag,
    input logic                          uslip_flag
);
    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(2*FRAME_BITS)+1)'(2*FRAME_BITS));

    // R4
    elastic_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == SB_ELASTIC) |-> fill <= ($clog2(2*FRAME_BITS)+1)'(ELASTIC_BITS));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cslip_pulse, uslip_pulse}));

    // R9
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == SB_BYPASS) |-> (fill == '0 && !cslip_pulse && !uslip_pulse));

    // R10
    csticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cslip_pulse |-> cslip_flag);

    // R10
    usticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uslip_pulse |-> uslip_flag);

    // R8
    fallback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fell_back && mode == 2'd2) |=> fell_back);

    // R6
    cslip_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cslip_pulse |-> (cur_mode == SB_TWO_FRAME || (cur_mode == SB_SHORT && fell_back)));
endmodule

bind sb_slip_buffer sb_checker #(.FRAME_BITS(FRAME_BITS), .ELASTIC_BITS(ELASTIC_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .cur_mode    (cur_mode),
    .fill        (fill),
    .fell_back   (fell_back),
    .cslip_pulse (cslip_pulse),
    .uslip_pulse (uslip_pulse),
    .cslip_flag  (cslip_flag),
    .uslip_flag  (uslip_flag)
);

// File: tb/tb_sb_slip_buffer.sv
`timescale 1ns/1ps
module tb_sb_slip_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       wr_en = 1'b0, wr_bit = 1'b0, wr_fs = 1'b0, rd_en = 1'b0, slip_clr = 1'b0;
    logic       rd_bit, rd_fs, fell_back, cslip_pulse, uslip_pulse, cslip_flag, uslip_flag;
    logic [9:0] fill;

    always #10 clk = ~clk;

    sb_slip_buffer dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_bit(wr_bit),
        .wr_fs(wr_fs), .rd_en(rd_en), .slip_clr(slip_clr), .rd_bit(rd_bit),
        .rd_fs(rd_fs), .fill(fill), .fell_back(fell_back), .cslip_pulse(cslip_pulse),
        .uslip_pulse(uslip_pulse), .cslip_flag(cslip_flag), .uslip_flag(uslip_flag)
    );

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit done = 0;
    int m_fill; bit m_fallen, m_cp, m_up, m_cs, m_us, m_change;
    logic [1:0] m_mode;
    bit pat [0:599];
    bit pfs [0:599];

    function automatic int start_fill(logic [1:0] m);
        return (m == 2'd0) ? 256 : (m == 2'd3) ? 0 : 32;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // requirement model of fill, fall-back and slip status
    task automatic model(bit w, bit r, bit c);
        bit el; int lim;
        m_cp = 0; m_up = 0; m_change = 0;
        if (!rst_n) begin
            m_mode = mode; m_fallen = 0; m_fill = start_fill(mode); m_cs = 0; m_us = 0;
            return;
        end
        if (mode != m_mode) begin
            m_change = 1; m_mode = mode; m_fallen = 0; m_fill = start_fill(mode);
        end else if (m_mode == 2'd3) begin
            m_fill = 0;
        end else begin
            el  = (m_mode == 2'd1) || (m_mode == 2'd2 && !m_fallen);
            lim = el ? 64 : 512;
            if ((w && !r && m_fill == lim) || (r && !w && m_fill == 0)) begin
                if (el) begin
                    m_up = 1;
                    if (m_mode == 2'd2) begin m_fallen = 1; m_fill = 256; end
                    else m_fill = 32;
                end else begin
                    m_cp = 1;
                    m_fill = w ? 257 : 255;
                end
            end else begin
                m_fill = m_fill + int'(w) - int'(r);
            end
        end
        m_cs = (m_cs && !c) || m_cp;
        m_us = (m_us && !c) || m_up;
    endtask

    task automatic cyc(bit w, bit b, bit f, bit r, bit c);
        wr_en = w; wr_bit = b; wr_fs = f; rd_en = r; slip_clr = c;
        model(w, r, c);
        @(posedge clk); #1;
        chk("R3 fill", int'(fill), m_fill);
        chk("R8 fell_back", int'(fell_back), int'(m_fallen));
        chk("R11 cslip_pulse", int'(cslip_pulse), int'(m_cp));
        chk("R11 uslip_pulse", int'(uslip_pulse), int'(m_up));
        chk("R10 cslip_flag", int'(cslip_flag), int'(m_cs));
        chk("R10 uslip_flag", int'(uslip_flag), int'(m_us));
    endtask

    task automatic do_reset(logic [1:0] m);
        mode = m; rst_n = 0;
        cyc(0, 0, 0, 0, 0);
        chk("R1 reset fill", int'(fill), start_fill(m));
        rst_n = 1;
    endtask

    initial begin
        while (!done && cycles < 200000) begin @(posedge clk); cycles++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected below 200000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            pat[i] = 1'($urandom);
            pfs[i] = (i % 256 == 0);
        end
        #5;
        // R6: fill two frames, overflow drops one frame, data from first bit
        do_reset(2'd0);
        for (int i = 0; i < 256; i++) cyc(1, pat[i], pfs[i], 0, 0);
        chk("R6 full fill", int'(fill), 512);
        cyc(1, pat[256], pfs[256], 0, 0);
        chk("R6 cslip", int'(cslip_pulse), 1);
        chk("R6 fill after slip", int'(fill), 257);
        for (int i = 0; i < 257; i++) begin
            cyc(0, 0, 0, 1, 0);
            chk("R2 R6 data", int'(rd_bit), int'(pat[i]));
            chk("R6 frame marker", int'(rd_fs), int'(pfs[i]));
        end
        // R7: empty then underflow repeats a frame
        do_reset(2'd0);
        for (int i = 0; i < 256; i++) cyc(1, pat[i], pfs[i], 1, 0);
        for (int i = 0; i < 256; i++) begin
            cyc(0, 0, 0, 1, 0);
            chk("R2 data", int'(rd_bit), int'(pat[i]));
        end
        cyc(0, 0, 0, 1, 0);
        chk("R7 cslip", int'(cslip_pulse), 1);
        chk("R7 fill", int'(fill), 255);
        chk("R7 repeated bit", int'(rd_bit), int'(pat[0]));
        cyc(0, 0, 0, 1, 0);
        chk("R7 next repeated", int'(rd_bit), int'(pat[1]));
        // R4/R5 elastic
        do_reset(2'd1);
        for (int i = 0; i < 33; i++) cyc(1, pat[i], 0, 0, 0);
        chk("R4 uslip", int'(uslip_pulse), 1);
        chk("R4 fill", int'(fill), 32);
        for (int i = 1; i < 33; i++) begin
            cyc(0, 0, 0, 1, 0);
            chk("R4 recentred data", int'(rd_bit), int'(pat[i]));
        end
        cyc(0, 0, 0, 1, 0);
        chk("R5 uslip", int'(uslip_pulse), 1);
        chk("R5 fill", int'(fill), 32);
        cyc(0, 0, 0, 0, 0);
        chk("R11 pulse one cycle", int'(uslip_pulse), 0);
        chk("R10 sticky held", int'(uslip_flag), 1);
        cyc(0, 0, 0, 0, 1);
        chk("R10 cleared", int'(uslip_flag), 0);
        // R8 short mode
        do_reset(2'd2);
        for (int i = 0; i < 33; i++) cyc(1, pat[i], 0, 0, 0);
        chk("R8 uslip on switch", int'(uslip_pulse), 1);
        chk("R8 fell_back", int'(fell_back), 1);
        chk("R8 fill", int'(fill), 256);
        for (int i = 0; i < 257; i++) cyc(1, pat[i], 0, 0, 0);
        chk("R8 controlled slip", int'(cslip_pulse), 1);
        chk("R8 fill 257", int'(fill), 257);
        // R1 mode change with strobes present
        mode = 2'd1;
        cyc(1, 1, 0, 0, 0);
        chk("R1 mode change fill", int'(fill), 32);
        chk("R1 fell_back cleared", int'(fell_back), 0);
        // R9 bypass
        mode = 2'd3;
        cyc(0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            automatic bit b = 1'($urandom), f = 1'($urandom), r = 1'($urandom);
            automatic logic pb = rd_bit, pf = rd_fs;
            cyc(1'($urandom), b, f, r, 0);
            chk("R9 bypass bit", int'(rd_bit), r ? int'(b) : int'(pb));
            chk("R9 bypass marker", int'(rd_fs), r ? int'(f) : int'(pf));
        end
        // random segments across modes
        for (int seg = 0; seg < 24; seg++) begin
            automatic int wp = 30 + $urandom_range(0, 40);
            automatic int rp = 30 + $urandom_range(0, 40);
            mode = 2'($urandom_range(0, 3));
            for (int k = 0; k < 800; k++) begin
                automatic bit w = ($urandom_range(0, 99) < wp);
                automatic bit r = ($urandom_range(0, 99) < rp);
                automatic bit b = 1'($urandom);
                automatic logic pb = rd_bit;
                cyc(w, b, 0, r, ($urandom_range(0, 99) < 2));
                if (m_mode == 2'd3 && !m_change)
                    chk("R9 random bypass", int'(rd_bit), r ? int'(b) : int'(pb));
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule